// File: doc/BRIEF.md
# External Interrupt Flag and Wake-Up Controller

This block watches three external interrupt inputs and keeps one sticky flag per input. Each channel is set either by a level condition (the input sits at its active level) or by an edge condition (the input moves to its active level). Per-channel mode and polarity bits choose between the two. Software reads and clears the flags over a small synchronous register bus. A clear is write-one-to-clear, and it is refused while a level-triggered input is still held active. This means a level source cannot be lost while it is still asserting.

Interrupt requests to the core are the flags masked by an externally supplied enable vector. Wake-up works separately: a wake-enable register decides which flags may end power-down, whatever the interrupt enables are. A power-down request is refused while any flag is set. So a channel can only wake the core if software cleared its flag before going to sleep.

Top module: `ext_irq_wake_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o`, `wake_o`, `pd_active_o` and `pd_reject_o` are 0, and no flag sets during the synchronizer fill.
- R2: Register offsets are 0 = flags, 1 = wake enable, 2 = trigger mode, 3 = polarity. Channel i sits in bit i (bits 2:0) of each. Bits 7:3 read as 0 and ignore writes.
- R3: With mode bit 0 (level), a flag is set while its input equals the polarity bit (0 = low, 1 = high). A change on an input reaches the flag on the third rising clock edge after it.
- R4: With mode bit 1 (edge), a flag is set when the input moves to the polarity level (0 = falling, 1 = rising). An input that stays at that level does not set the flag again once it is cleared.
- R5: A flag stays set until 1 is written to its bit at offset 0. Writing 0 has no effect.
- R6: In level mode, writing 1 to a flag whose input is still active leaves it set. The same write clears it once the input is inactive.
- R7: `irq_o[i]` equals flag i AND `irq_en_i[i]`.
- R8: A `pd_req_i` pulse with any flag set is refused: `pd_reject_o` is 1 for the next cycle and `pd_active_o` stays 0. With no flag set, `pd_active_o` becomes 1 on the next cycle.
- R9: In power-down, a set flag on a wake-enabled channel raises `wake_o` for one cycle and drops `pd_active_o` on the next edge, whatever `irq_en_i` is. Outside power-down, `wake_o` is 0.
- R10: In power-down, a flag on a channel whose wake-enable bit is 0 does not end power-down, although its `irq_o` may assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 3 | Asynchronous external interrupt inputs |
| irq_en_i | input | 3 | Per-channel interrupt enable toward the core |
| addr_i | input | 2 | Register offset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pd_req_i | input | 1 | Request to enter power-down (one-cycle pulse) |
| pd_active_o | output | 1 | Power-down state |
| pd_reject_o | output | 1 | One-cycle pulse when a power-down request is refused |
| irq_o | output | 3 | Masked interrupt requests |
| wake_o | output | 1 | Wake-up event while in power-down |

## Verification
The assertions check the following on every cycle:
- a refused clear never drops a level-held flag;
- flags stay sticky;
- edge and level hits always land in the flag;
- a refused power-down never enters;
- a wake always leaves power-down on the next edge;
- unmasked wake sources are the only way out of power-down.

Other behaviours can only be shown by the bench's scenarios:
- the exact three-edge input latency;
- the register map with its reserved bits;
- the difference between edges and held levels over time;
- the full sleep, wake, clear and sleep-again sequence with interrupt enables deliberately opposite to the wake enables.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int unsigned OFS_FLAGS = 0;
    localparam int unsigned OFS_WAKE  = 1;
    localparam int unsigned OFS_MODE  = 2;
    localparam int unsigned OFS_POL   = 3;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int unsigned NCH    = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_i,
    output logic [NCH-1:0] sync_o,
    output logic           valid_o
);
    localparam int unsigned PRIME_W = STAGES + 1;

    typedef struct packed {
        logic [STAGES-1:0][NCH-1:0] pipe;
        logic [PRIME_W-1:0]         prime;
    } sync_s;

    sync_s sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe[0]  = pin_i;
        sync_d.prime[0] = 1'b1;
        for (int st = 1; st < int'(STAGES); st++) begin
            sync_d.pipe[st] = sync_q.pipe[st-1];
        end
        for (int pb = 1; pb < int'(PRIME_W); pb++) begin
            sync_d.prime[pb] = sync_q.prime[pb-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o  = sync_q.pipe[STAGES-1];
    assign valid_o = sync_q.prime[PRIME_W-1];

    p_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);
endmodule

// File: rtl/eirq_channel.sv
module eirq_channel
    import eirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_i,
    input  logic  valid_i,
    input  trig_e mode_i,
    input  logic  pol_i,
    input  logic  clr_i,
    output logic  flag_o
);
    typedef struct packed {
        logic prev;
        logic flag;
    } chan_s;

    chan_s ch_d, ch_q;
    logic  at_active;
    logic  lvl_hit;
    logic  edge_hit;

    always_comb begin
        at_active = (sync_i == pol_i) && valid_i;
        lvl_hit   = at_active && (mode_i == TRIG_LEVEL);
        edge_hit  = at_active && (mode_i == TRIG_EDGE) && (ch_q.prev != pol_i);
        ch_d      = ch_q;
        ch_d.prev = sync_i;
        ch_d.flag = (ch_q.flag && !(clr_i && !lvl_hit)) || lvl_hit || edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign flag_o = ch_q.flag;

    p_level_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_hit |=> flag_o);
    p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> flag_o);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    p_clear_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && lvl_hit) |=> flag_o);
endmodule

// File: rtl/eirq_pd_gate.sv
module eirq_pd_gate #(
    parameter int unsigned NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pd_req_i,
    input  logic [NCH-1:0] flags_i,
    input  logic [NCH-1:0] wake_en_i,
    output logic           pd_active_o,
    output logic           pd_reject_o,
    output logic           wake_o
);
    typedef struct packed {
        logic active;
        logic reject;
    } pd_s;

    pd_s  pd_d, pd_q;
    logic any_flag;
    logic wake_src;

    always_comb begin
        any_flag  = |flags_i;
        wake_src  = |(flags_i & wake_en_i);
        pd_d      = pd_q;
        pd_d.reject = pd_req_i && !pd_q.active && any_flag;
        if (pd_q.active) pd_d.active = !wake_src;
        else             pd_d.active = pd_req_i && !any_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    assign pd_active_o = pd_q.active;
    assign pd_reject_o = pd_q.reject;
    assign wake_o      = pd_q.active && wake_src;

    p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_req_i && !pd_active_o && (flags_i != '0)) |=> (pd_reject_o && !pd_active_o));
    p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_req_i && !pd_active_o && (flags_i == '0)) |=> pd_active_o);
    p_wake_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !pd_active_o);
    p_masked_stay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active_o && ((flags_i & wake_en_i) == '0)) |=> pd_active_o);
endmodule

// File: rtl/ext_irq_wake_ctrl.sv
module ext_irq_wake_ctrl
    import eirq_pkg::*;
#(
    parameter int unsigned NCH    = 3,
    parameter int unsigned DW     = 8,
    parameter int unsigned AW     = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_i,
    input  logic [NCH-1:0] irq_en_i,
    input  logic [AW-1:0]  addr_i,
    input  logic           wr_en_i,
    input  logic [DW-1:0]  wdata_i,
    output logic [DW-1:0]  rdata_o,
    input  logic           pd_req_i,
    output logic           pd_active_o,
    output logic           pd_reject_o,
    output logic [NCH-1:0] irq_o,
    output logic           wake_o
);
    localparam logic [AW-1:0] A_FLAGS = AW'(OFS_FLAGS);
    localparam logic [AW-1:0] A_WAKE  = AW'(OFS_WAKE);
    localparam logic [AW-1:0] A_MODE  = AW'(OFS_MODE);
    localparam logic [AW-1:0] A_POL   = AW'(OFS_POL);

    typedef struct packed {
        logic [NCH-1:0] wake_en;
        logic [NCH-1:0] mode;
        logic [NCH-1:0] pol;
    } cfg_s;

    cfg_s           cfg_d, cfg_q;
    logic [NCH-1:0] sync_w;
    logic           sync_valid;
    logic [NCH-1:0] clr_w;
    logic [NCH-1:0] flags_w;
    logic [DW-1:0]  rd_w;
    logic           unused_wdata;

    assign unused_wdata = ^wdata_i[DW-1:NCH];

    eirq_sync #(.NCH(NCH), .STAGES(STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .sync_o  (sync_w),
        .valid_o (sync_valid)
    );

    always_comb begin
        cfg_d = cfg_q;
        clr_w = '0;
        if (wr_en_i) begin
            unique case (addr_i)
                A_FLAGS: clr_w         = wdata_i[NCH-1:0];
                A_WAKE:  cfg_d.wake_en = wdata_i[NCH-1:0];
                A_MODE:  cfg_d.mode    = wdata_i[NCH-1:0];
                A_POL:   cfg_d.pol     = wdata_i[NCH-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar ci = 0; ci < NCH; ci++) begin : g_chan
        eirq_channel chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_i  (sync_w[ci]),
            .valid_i (sync_valid),
            .mode_i  (trig_e'(cfg_q.mode[ci])),
            .pol_i   (cfg_q.pol[ci]),
            .clr_i   (clr_w[ci]),
            .flag_o  (flags_w[ci])
        );
    end

    eirq_pd_gate #(.NCH(NCH)) pd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req_i    (pd_req_i),
        .flags_i     (flags_w),
        .wake_en_i   (cfg_q.wake_en),
        .pd_active_o (pd_active_o),
        .pd_reject_o (pd_reject_o),
        .wake_o      (wake_o)
    );

    always_comb begin
        rd_w = '0;
        unique case (addr_i)
            A_FLAGS: rd_w[NCH-1:0] = flags_w;
            A_WAKE:  rd_w[NCH-1:0] = cfg_q.wake_en;
            A_MODE:  rd_w[NCH-1:0] = cfg_q.mode;
            A_POL:   rd_w[NCH-1:0] = cfg_q.pol;
            default: ;
        endcase
    end

    assign rdata_o = rd_w;
    assign irq_o   = flags_w & irq_en_i;

    p_wake_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_WAKE) |=> (cfg_q.wake_en == $past(wdata_i[NCH-1:0])));
    p_no_flag_prime_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_valid |=> (flags_w == '0));
endmodule

// File: tb/ext_irq_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_wake_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin = 3'b111;
    logic [2:0] irq_en = 3'b000;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       pd_req = 1'b0;
    logic       pd_active, pd_reject, wake;
    logic [2:0] irq;

    int checks = 0;
    int errors = 0;
    int wake_cnt = 0;
    bit done = 0;

    logic [2:0] mf = 3'b000, mwen = 3'b000, mmode = 3'b000, mpol = 3'b000, mpin = 3'b111;

    always #4 clk = ~clk;

    ext_irq_wake_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_en_i(irq_en),
        .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
        .pd_req_i(pd_req), .pd_active_o(pd_active), .pd_reject_o(pd_reject),
        .irq_o(irq), .wake_o(wake)
    );

    always @(negedge clk) if (rst_n && wake) wake_cnt++;

    function automatic logic [2:0] lvl_act();
        return ~mmode & ~(mpin ^ mpol);
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: mf = (mf & ~d[2:0]) | lvl_act();
            2'd1: mwen = d[2:0];
            2'd2: mmode = d[2:0];
            default: mpol = d[2:0];
        endcase
        tick(2);
        mf = mf | lvl_act();
    endtask

    task automatic set_pins(logic [2:0] nv);
        logic [2:0] ev;
        ev = mmode & (mpin ^ nv) & ~(nv ^ mpol);
        mpin = nv; pin = nv;
        tick(4);
        mf = mf | ev | lvl_act();
    endtask

    task automatic check_flags(string tag);
        logic [7:0] v;
        rd(2'd0, v);
        check(tag, v, {5'b0, mf});
    endtask

    task automatic pd_request();
        pd_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pd_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        tick(2);
        rst_n = 1'b1;
        tick(6);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reg reset", v, 8'h00);
        end
        check("R1 outputs", {4'b0, irq, wake}, 8'h00);
        check("R1 pd", {6'b0, pd_active, pd_reject}, 8'h00);

        // R2 reserved bits and map
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R2 wake reg reserved bits", v, 8'h07);
        wr(2'd1, 8'h00);

        // R3 level latency, low active on channel 0
        pin = 3'b110; mpin = 3'b110;
        tick(2);
        rd(2'd0, v); check("R3 flag not yet", v, 8'h00);
        tick(1);
        rd(2'd0, v); check("R3 flag after three edges", v, 8'h01);
        mf = 3'b001;

        // R6 clear refused while active
        wr(2'd0, 8'h01);
        check_flags("R6 clear refused");
        set_pins(3'b111);
        check_flags("R5 sticky after release");
        wr(2'd0, 8'h00);
        check_flags("R5 write zero no effect");
        wr(2'd0, 8'h01);
        check_flags("R6 clear after release");
        check(" R6 flag zero", {5'b0, mf}, 8'h00);

        // R4 edge mode
        wr(2'd2, 8'h06);
        wr(2'd3, 8'h02);
        check_flags("R4 no edge idle");
        set_pins(3'b101);
        check_flags("R4 falling ignored on rising channel");
        set_pins(3'b111);
        check_flags("R4 rising sets");
        check("R4 expect ch1", {5'b0, mf}, 8'h02);
        wr(2'd0, 8'h02);
        check_flags("R4 no reset while held");
        set_pins(3'b011);
        check_flags("R4 falling sets ch2");

        // R7 interrupt masking
        irq_en = 3'b100; #1;
        check("R7 irq enabled", {5'b0, irq}, 8'h04);
        irq_en = 3'b010; #1;
        check("R7 irq masked", {5'b0, irq}, 8'h00);

        // R8 refusal with flag set
        pd_request();
        check("R8 refused", {6'b0, pd_active, pd_reject}, 8'h01);
        tick(1);
        check("R8 reject one cycle", {7'b0, pd_reject}, 8'h00);
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h02);
        pd_request();
        check("R8 entered", {6'b0, pd_active, pd_reject}, 8'h02);

        // R10 non-wake channel
        irq_en = 3'b001;
        set_pins(3'b010);
        check_flags("R10 flag set");
        check("R10 still asleep", {7'b0, pd_active}, 8'h01);
        check("R10 irq asserted", {5'b0, irq}, 8'h01);
        check("R10 no wake", wake_cnt[7:0], 8'h00);
        set_pins(3'b011);
        wr(2'd0, 8'h01);

        // R9 wake without interrupt enable
        irq_en = 3'b000;
        set_pins(3'b001);
        check("R9 asleep before edge", {7'b0, pd_active}, 8'h01);
        set_pins(3'b011);
        check("R9 woke", {7'b0, pd_active}, 8'h00);
        check("R9 one wake pulse", wake_cnt[7:0], 8'h01);
        check("R9 no irq", {5'b0, irq}, 8'h00);

        // R8 retry needs clear
        pd_request();
        check("R8 retry refused", {6'b0, pd_active, pd_reject}, 8'h01);
        wr(2'd0, 8'h02);
        pd_request();
        check("R8 retry after clear", {6'b0, pd_active, pd_reject}, 8'h02);
        set_pins(3'b001);
        set_pins(3'b011);
        check("R9 second wake", {7'b0, pd_active}, 8'h00);
        check("R9 wake count", wake_cnt[7:0], 8'h02);
        wr(2'd0, 8'h07);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [7:0] r;
            op = $urandom_range(0, 4);
            r = 8'($urandom);
            case (op)
                0: set_pins(r[2:0]);
                1: wr(2'd1, r);
                2: wr(2'd2, r);
                3: wr(2'd3, r);
                default: wr(2'd0, r);
            endcase
            irq_en = 3'($urandom); #1;
            check_flags("R3 R4 R6 random flags");
            check("R7 random irq", {5'b0, irq}, {5'b0, mf & irq_en});
            rd(2'd1, v); check("R2 random wake reg", v, {5'b0, mwen});
            rd(2'd2, v); check("R2 random mode reg", v, {5'b0, mmode});
            rd(2'd3, v); check("R2 random pol reg", v, {5'b0, mpol});
            check("R9 no wake when awake", {7'b0, wake}, 8'h00);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule